// File: doc/BRIEF.md
# Dithered Fractional-Resolution PWM Generator

This block produces a pulse-width-modulated output whose average duty is finer than one counter step. The duty command has two parts: a 16-bit integer width N and an 8-bit fraction. In each period the pulse is either N or N+1 clocks wide. A first-order sigma-delta accumulator chooses between the two. It adds the fraction once per period, and its carry-out widens that period by one count. Over 256 periods the average width is therefore N + frac/256. The wide periods are spread out rather than grouped, so the ripple stays close to that of a single-step change.

Commands are captured at the boundary between periods, so a write made part-way through a period never disturbs it. A one-cycle strobe marks the first clock of every period, which lets firmware or a bench count periods. Enable gates the whole generator. Disabling forces the output low and restarts the count, but the accumulator keeps its remainder.

Top module: `dither_pwm`

## Requirements
- R1: Synchronous reset (rst high) drives pwm_o and period_start_o low and clears the accumulator, so the first period after reset with fraction 128 uses width N.
- R2: While en is high, period_start_o is high for exactly one clock at the first clock of each period. Consecutive strobes are max(P,1) clocks apart, where P is the captured period value (P=0 behaves as 1).
- R3: Within a period of width W, pwm_o is high on the first W clocks and low on the rest. W is always N or N+1.
- R4: A width of 0 keeps pwm_o low for the whole period. A width equal to or greater than P keeps it high for the whole period.
- R5: At each period start, the 8-bit accumulator adds the fraction. A carry out of bit 7 selects width N+1 for that period; otherwise the width is N. Between period starts the accumulator is unchanged.
- R6: With a constant command, any 256 consecutive periods contain exactly frac wide periods.
- R7: With a fraction of 128 or less, two wide periods are never adjacent.
- R8: Period, integer and fraction inputs are sampled only at the period start. A change made mid-period takes effect from the next period.
- R9: With en low, pwm_o and period_start_o are low and the accumulator holds its value. The first clock after en returns high starts a new period with a strobe.
- R10: N=65535 with a carry gives a width of 65536, with no wrap to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| period_i | input | 16 | Period length in clocks |
| duty_int_i | input | 16 | Integer pulse width N |
| duty_frac_i | input | 8 | Fractional duty, units of 1/256 count |
| pwm_o | output | 1 | PWM output |
| period_start_o | output | 1 | One-cycle strobe on the first clock of each period |

## Verification
The bench builds the block with its default 16-bit counter and 8-bit fraction. That keeps a full 256-period dither cycle of short periods (a few thousand clocks) within a single run, so the exact count of wide periods and their spacing can be checked over a whole accumulator cycle. It also brings the top integer code 65535 within reach, where the carry must widen the pulse to 65536 rather than wrap it to zero.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int DEF_CNT_W  = 16;
    localparam int DEF_FRAC_W = 8;

    typedef enum logic {
        TB_IDLE = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    function automatic logic [DEF_CNT_W-1:0] final_count(input logic [DEF_CNT_W-1:0] per);
        return (per == '0) ? '0 : per - 1'b1;
    endfunction

endpackage

// File: rtl/dpwm_sigma.sv
module dpwm_sigma #(
    parameter int FRAC_W = dpwm_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, frac};
    assign carry_o = sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    // R5: remainder only moves at a period start
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(acc_q));

endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
    parameter int CNT_W = dpwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W:0]   width_i,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W:0]   width_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            width_q  <= '0;
        end else if (load) begin
            period_q <= period_i;
            width_q  <= width_i;
        end
    end

    // R8: shadows are frozen inside a period
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(period_q) && $stable(width_q)));

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_q,
    input  logic [CNT_W:0]   width_q,
    input  logic [CNT_W:0]   width_new,
    output logic             load_o,
    output logic             pwm_o,
    output logic             start_o
);
    tb_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W:0]   cnt_next_ext;

    assign last_cnt     = (period_q == '0) ? '0 : period_q - 1'b1;
    assign load_o       = en && ((state_q == TB_IDLE) || (cnt_q >= last_cnt));
    assign cnt_next_ext = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
            pwm_o   <= 1'b0;
            start_o <= 1'b0;
        end else if (!en) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
            pwm_o   <= 1'b0;
            start_o <= 1'b0;
        end else if (load_o) begin
            state_q <= TB_RUN;
            cnt_q   <= '0;
            pwm_o   <= (width_new != '0);
            start_o <= 1'b1;
        end else begin
            cnt_q   <= cnt_next_ext[CNT_W-1:0];
            pwm_o   <= (cnt_next_ext < width_q);
            start_o <= 1'b0;
        end
    end

    // R2: strobe marks count zero
    p_strobe_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (cnt_q == '0));

    // R2: count stays inside the captured period
    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == TB_RUN && period_q != '0) |-> (cnt_q < period_q));

    // R4: zero width keeps the line low
    p_zero_low_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == TB_RUN && width_q == '0) |-> !pwm_o);

    // R4: width at or past the period keeps the line high
    p_full_high_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == TB_RUN && period_q != '0 && width_q >= {1'b0, period_q}) |-> pwm_o);

    // R9: disabled generator is silent
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm_o && !start_o));

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm #(
    parameter int CNT_W  = dpwm_pkg::DEF_CNT_W,
    parameter int FRAC_W = dpwm_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  duty_int_i,
    input  logic [FRAC_W-1:0] duty_frac_i,
    output logic              pwm_o,
    output logic              period_start_o
);
    logic             load;
    logic             carry;
    logic [CNT_W:0]   width_new;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W:0]   width_q;

    assign width_new = {1'b0, duty_int_i} + {{CNT_W{1'b0}}, carry};

    dpwm_sigma #(.FRAC_W(FRAC_W)) u_sigma (
        .clk     (clk),
        .rst     (rst),
        .step    (load),
        .frac    (duty_frac_i),
        .carry_o (carry)
    );

    dpwm_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .period_i (period_i),
        .width_i  (width_new),
        .period_q (period_q),
        .width_q  (width_q)
    );

    dpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .period_q  (period_q),
        .width_q   (width_q),
        .width_new (width_new),
        .load_o    (load),
        .pwm_o     (pwm_o),
        .start_o   (period_start_o)
    );

    // R3, R10: captured width is N or N+1 of the command seen at the boundary
    p_width_adjacent_r3: assert property (@(posedge clk) disable iff (rst)
        period_start_o |-> ((width_q >= {1'b0, $past(duty_int_i)}) &&
                            (width_q <= {1'b0, $past(duty_int_i)} + 1'b1)));

endmodule

// File: tb/dither_pwm_bench.sv
module dither_pwm_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] period_i = '0;
    logic [15:0] duty_int_i = '0;
    logic [7:0]  duty_frac_i = '0;
    logic        pwm_o;
    logic        period_start_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dither_pwm u_dither_pwm (
        .clk(clk), .rst(rst), .en(en), .period_i(period_i),
        .duty_int_i(duty_int_i), .duty_frac_i(duty_frac_i),
        .pwm_o(pwm_o), .period_start_o(period_start_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: period length, width choice from fractional remainder
    int m_acc = 0, m_w = 0, m_per = 0, m_pos = 0;
    bit m_run = 0, m_pwm = 0, m_start = 0, model_on = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_w = 0; m_per = 0; m_pos = 0; m_run = 0; m_pwm = 0; m_start = 0;
        end else if (!en) begin
            m_run = 0; m_pos = 0; m_pwm = 0; m_start = 0;
        end else if (!m_run || m_pos + 1 >= ((m_per == 0) ? 1 : m_per)) begin
            m_acc = m_acc + int'(duty_frac_i);
            m_w   = int'(duty_int_i) + ((m_acc >= 256) ? 1 : 0);
            m_acc = m_acc % 256;
            m_per = int'(period_i);
            m_pos = 0; m_run = 1; m_start = 1;
            m_pwm = (m_w > 0);
        end else begin
            m_pos++; m_start = 0;
            m_pwm = (m_pos < m_w);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk("R3", "pwm_o vs model", int'(pwm_o), int'(m_pwm));
            chk("R2", "period_start_o vs model", int'(period_start_o), int'(m_start));
        end
    end

    // period monitor
    int len_q[$];
    int high_q[$];
    int cur_len = 0, cur_high = 0;
    bit in_per = 0;
    always @(negedge clk) begin
        if (rst || !en) begin
            in_per = 0;
        end else if (period_start_o) begin
            if (in_per) begin
                len_q.push_back(cur_len);
                high_q.push_back(cur_high);
            end
            cur_len = 1; cur_high = int'(pwm_o); in_per = 1;
        end else if (in_per) begin
            cur_len++; cur_high += int'(pwm_o);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic setup(input int p, input int n, input int f);
        period_i = 16'(p); duty_int_i = 16'(n); duty_frac_i = 8'(f);
    endtask

    task automatic collect(input int n);
        len_q.delete(); high_q.delete();
        en = 1'b1;
        while (len_q.size() < n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int wide, adj, prev;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        model_on = 1;
        chk("R1", "pwm_o in reset", int'(pwm_o), 0);
        chk("R1", "strobe in reset", int'(period_start_o), 0);
        rst = 1'b0;

        // R2 R3: plain width
        setup(10, 3, 0);
        collect(4);
        chk("R2", "period length", len_q[1], 10);
        chk("R3", "high count N=3", high_q[1], 3);

        // R1 R5: half fraction alternates, narrow first after reset
        do_reset(); setup(10, 3, 128);
        collect(4);
        chk("R1", "first width after reset", high_q[0], 3);
        chk("R5", "second width", high_q[1], 4);
        chk("R5", "third width", high_q[2], 3);
        chk("R5", "fourth width", high_q[3], 4);

        // R6 R7: fraction 85 over a full cycle
        do_reset(); setup(8, 2, 85);
        collect(256);
        wide = 0; adj = 0; prev = 0;
        foreach (high_q[i]) begin
            if (high_q[i] == 3) begin wide++; if (prev) adj++; prev = 1; end
            else prev = 0;
        end
        chk("R6", "wide periods frac=85", wide, 85);
        chk("R7", "adjacent wide periods", adj, 0);

        // R6: near-full fraction
        do_reset(); setup(6, 1, 255);
        collect(257);
        wide = 0;
        for (int i = 1; i < 257; i++) if (high_q[i] == 2) wide++;
        chk("R6", "wide periods frac=255", wide, 255);

        // R4: zero and full widths
        do_reset(); setup(12, 0, 0);
        collect(3);
        chk("R4", "zero width high count", high_q[1], 0);
        do_reset(); setup(12, 12, 0);
        collect(3);
        chk("R4", "full width high count", high_q[1], 12);

        // R10: top integer with carry
        do_reset(); setup(20, 65535, 255);
        collect(3);
        chk("R10", "top code high count", high_q[1], 20);

        // R2: period zero acts as one
        do_reset(); setup(0, 0, 0);
        collect(4);
        chk("R2", "period 0 length", len_q[2], 1);

        // R8: mid-period change
        do_reset(); setup(10, 2, 0);
        en = 1'b1;
        do @(negedge clk); while (!period_start_o);
        repeat (3) @(negedge clk);
        len_q.delete(); high_q.delete();
        setup(5, 7, 0);
        while (len_q.size() < 2) @(negedge clk);
        chk("R8", "current period length kept", len_q[0], 10);
        chk("R8", "current width kept", high_q[0], 2);
        chk("R8", "new period length", len_q[1], 5);
        chk("R8", "new width clipped high", high_q[1], 5);

        // R9: disable holds remainder
        do_reset(); setup(10, 3, 128);
        en = 1'b1;
        do @(negedge clk); while (!period_start_o);
        repeat (4) @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9", "pwm low when disabled", int'(pwm_o), 0);
            chk("R9", "strobe low when disabled", int'(period_start_o), 0);
        end
        len_q.delete(); high_q.delete();
        en = 1'b1;
        @(negedge clk);
        chk("R9", "strobe on re-enable", int'(period_start_o), 1);
        while (len_q.size() < 2) @(negedge clk);
        chk("R9", "held remainder gives wide", high_q[0], 4);
        chk("R9", "then narrow", high_q[1], 3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule